// File: doc/BRIEF.md
# Serial Wire Debug Host Packet Engine

This block is the host side of a two-wire serial debug link. It handles one transaction at a time. A transaction is either a framed packet or a raw bit burst. A framed packet carries a port select (debug port or access port), a read/write flag, a two-bit register address and, for writes, a 32-bit word. The engine serialises the eight-bit request header and releases the data line for the turnaround bit. It then captures the three-bit acknowledge from the target. When the acknowledge is OK, it either drives 32 write bits plus parity or captures 32 read bits plus parity. It hands the line back with the required undriven turnaround bits. Its result is the acknowledge, the read word and a flag for bad read parity.

A raw burst shifts out between 1 and 32 bits, least significant first. Higher layers chain such bursts to build line-reset and protocol-switch sequences. The wire clock is produced inside the block: a clock-enable divider sets the length of each low and each high half period, counted in system clock cycles. The data line leaves the block as a value plus an output enable, so that a pad ring can form the bidirectional pin.

Top module: `swd_host_engine`

## Requirements
- R1: After reset and between transactions, `busy` is low, `swclk` is low and the data line is driven low (`swdio_oe`=1, `swdio_o`=0).
- R2: Every wire bit is a low half period followed by a high half period, each lasting `clk_div`+1 system clock cycles. `swdio_o` and `swdio_oe` change only while `swclk` is low.
- R3: A packet starts with eight driven header bits in this wire order: 1, `req_ap`, `req_rd`, `req_addr[0]`, `req_addr[1]`, the even parity of those four bits, 0, 1.
- R4: After the header, one bit is left undriven (`swdio_oe`=0). Three acknowledge bits then follow undriven, sampled in the system cycle in which `swclk` rises. The first bit sampled is bit 0 of the acknowledge, and 3'b001 means OK.
- R5: On an OK write, one undriven turnaround bit is followed by 33 driven bits: `req_wdata` least significant bit first, then its even parity. The transaction ends after the parity bit, with no further turnaround (46 wire bits).
- R6: On an OK read, 33 bits are sampled (data least significant bit first, then parity), followed by one undriven turnaround bit (46 wire bits). `rsp_rdata` returns the word. `rsp_perr` is 1 exactly when the 33 sampled bits hold an odd number of ones.
- R7: When the acknowledge is not OK, the data phase is skipped. One undriven turnaround bit ends the transaction (13 wire bits). `rsp_ack` reports the received value, and `rsp_rdata` and `rsp_perr` are 0.
- R8: A raw burst (`req_raw`=1) drives `req_raw_cnt`+1 bits of `req_wdata`, least significant bit first, with no turnaround. It reports `rsp_ack`=0, `rsp_rdata`=0 and `rsp_perr`=0.
- R9: `rsp_valid` pulses for one cycle, in the cycle in which `busy` falls. A request presented in that same cycle is accepted at once, and `busy` is high in the next cycle.
- R10: A `req_valid` pulse that arrives while `busy` is high is ignored. It produces no wire activity and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | Half period of the wire clock, in system cycles minus one |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_raw | input | 1 | 1 selects a raw bit burst, 0 a framed packet |
| req_ap | input | 1 | 1 addresses the access port, 0 the debug port |
| req_rd | input | 1 | 1 read, 0 write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write word, or the raw bits to send |
| req_raw_cnt | input | 5 | Raw burst length minus one |
| busy | output | 1 | A transaction is in progress |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_ack | output | 3 | Received acknowledge (0 for raw bursts) |
| rsp_rdata | output | 32 | Read word from an OK read, otherwise 0 |
| rsp_perr | output | 1 | Read parity mismatch |
| swclk | output | 1 | Wire clock |
| swdio_o | output | 1 | Data value driven to the pin |
| swdio_oe | output | 1 | Data pin output enable |
| swdio_i | input | 1 | Data value read from the pin |

## Verification
The completion strobe of one transaction and the acceptance of the next can fall in the same cycle. The bench provokes this by holding a read request valid throughout a write. It judges the overlap by seeing `busy` low with `rsp_valid` high in one cycle and `busy` high in the next. A scoreboard then confirms that both responses arrive in order with the right wire-bit counts. A second pairing is a request strobe during the read data phase. The bench shows that this strobe is dropped by finding exactly one response and a quiet line afterwards.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  localparam int HDR_BITS  = 8;
  localparam int ACK_BITS  = 3;
  localparam int DATA_BITS = 32;

  localparam logic [ACK_BITS-1:0] ACK_OK = 3'b001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_TRN_REQ,
    ST_ACK,
    ST_TRN_WR,
    ST_WDATA,
    ST_RDATA,
    ST_TRN_END,
    ST_RAW
  } swd_state_e;

  // header word, bit 0 leaves the wire first
  function automatic logic [HDR_BITS-1:0] build_hdr(input logic ap, input logic rd,
                                                    input logic [1:0] addr);
    logic par;
    par = ap ^ rd ^ addr[0] ^ addr[1];
    return {1'b1, 1'b0, par, addr[1], addr[0], rd, ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_tick_gen.sv
module swd_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q >= div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q >= div);

endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture #(
  parameter int ACK_W = 3,
  parameter int DAT_W = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             smp_ack,
  input  logic             smp_dat,
  input  logic             din,
  output logic [ACK_W-1:0] ack_q,
  output logic [DAT_W-1:0] dat_q
);

  // right shifters: first sampled bit ends up at position 0
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ack_q <= '0;
      dat_q <= '0;
    end else begin
      if (smp_ack) ack_q <= {din, ack_q[ACK_W-1:1]};
      if (smp_dat) dat_q <= {din, dat_q[DAT_W-1:1]};
    end
  end

endmodule

// File: rtl/swd_frame_seq.sv
module swd_frame_seq
  import swd_host_pkg::*;
#(
  parameter int TURN_BITS = 1,
  parameter int RAW_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 req_valid,
  input  logic                 req_raw,
  input  logic                 req_ap,
  input  logic                 req_rd,
  input  logic [1:0]           req_addr,
  input  logic [DATA_BITS-1:0] req_wdata,
  input  logic [RAW_W-1:0]     req_raw_cnt,
  input  logic [ACK_BITS-1:0]  ack_in,
  input  logic [DATA_BITS:0]   dat_in,
  output logic                 busy,
  output logic                 cap_clr,
  output logic                 smp_ack,
  output logic                 smp_dat,
  output logic                 swclk,
  output logic                 swdio_o,
  output logic                 swdio_oe,
  output logic                 rsp_valid,
  output logic [ACK_BITS-1:0]  rsp_ack,
  output logic [DATA_BITS-1:0] rsp_rdata,
  output logic                 rsp_perr
);

  localparam int TX_W  = DATA_BITS + 1;
  localparam int CNT_W = $clog2(TX_W);

  swd_state_e        state_q, nxt_state;
  logic [CNT_W-1:0]  cnt_q, nxt_cnt;
  logic [TX_W-1:0]   tx_q, wd_q;
  logic              sclk_q, dout_q, oe_q;
  logic              rd_q, raw_q;
  logic              nxt_oe, nxt_load, nxt_done;
  logic              accept, rise, fall, last, rd_ok;
  logic [HDR_BITS-1:0] hdr_w;

  always_comb begin
    accept  = req_valid && (state_q == ST_IDLE);
    rise    = tick && !sclk_q;
    fall    = tick && sclk_q;
    last    = (cnt_q == '0);
    hdr_w   = build_hdr(req_ap, req_rd, req_addr);
    rd_ok   = !raw_q && rd_q && (ack_in == ACK_OK);
    smp_ack = rise && (state_q == ST_ACK);
    smp_dat = rise && (state_q == ST_RDATA);
    cap_clr = accept;
  end

  // successor of each phase, taken on the falling edge of its last bit
  always_comb begin
    nxt_state = state_q;
    nxt_cnt   = '0;
    nxt_oe    = 1'b0;
    nxt_load  = 1'b0;
    nxt_done  = 1'b0;
    unique case (state_q)
      ST_HDR: begin
        nxt_state = ST_TRN_REQ;
        nxt_cnt   = CNT_W'(TURN_BITS - 1);
      end
      ST_TRN_REQ: begin
        nxt_state = ST_ACK;
        nxt_cnt   = CNT_W'(ACK_BITS - 1);
      end
      ST_ACK: begin
        if (ack_in != ACK_OK) begin
          nxt_state = ST_TRN_END;
          nxt_cnt   = CNT_W'(TURN_BITS - 1);
        end else if (rd_q) begin
          nxt_state = ST_RDATA;
          nxt_cnt   = CNT_W'(DATA_BITS);
        end else begin
          nxt_state = ST_TRN_WR;
          nxt_cnt   = CNT_W'(TURN_BITS - 1);
        end
      end
      ST_TRN_WR: begin
        nxt_state = ST_WDATA;
        nxt_cnt   = CNT_W'(DATA_BITS);
        nxt_oe    = 1'b1;
        nxt_load  = 1'b1;
      end
      ST_RDATA: begin
        nxt_state = ST_TRN_END;
        nxt_cnt   = CNT_W'(TURN_BITS - 1);
      end
      ST_WDATA, ST_TRN_END, ST_RAW: begin
        nxt_state = ST_IDLE;
        nxt_oe    = 1'b1;
        nxt_done  = 1'b1;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      tx_q      <= '0;
      wd_q      <= '0;
      sclk_q    <= 1'b0;
      dout_q    <= 1'b0;
      oe_q      <= 1'b1;
      rd_q      <= 1'b0;
      raw_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ack   <= '0;
      rsp_rdata <= '0;
      rsp_perr  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        raw_q  <= req_raw;
        rd_q   <= req_rd;
        wd_q   <= {^req_wdata, req_wdata};
        sclk_q <= 1'b0;
        oe_q   <= 1'b1;
        if (req_raw) begin
          state_q <= ST_RAW;
          cnt_q   <= CNT_W'(req_raw_cnt);
          tx_q    <= {1'b0, req_wdata};
          dout_q  <= req_wdata[0];
        end else begin
          state_q <= ST_HDR;
          cnt_q   <= CNT_W'(HDR_BITS - 1);
          tx_q    <= {{(TX_W-HDR_BITS){1'b0}}, hdr_w};
          dout_q  <= hdr_w[0];
        end
      end else if (rise) begin
        sclk_q <= 1'b1;
      end else if (fall) begin
        sclk_q <= 1'b0;
        if (!last) begin
          cnt_q  <= cnt_q - 1'b1;
          tx_q   <= tx_q >> 1;
          dout_q <= tx_q[1];
        end else begin
          state_q <= nxt_state;
          cnt_q   <= nxt_cnt;
          oe_q    <= nxt_oe;
          if (nxt_load) begin
            tx_q   <= wd_q;
            dout_q <= wd_q[0];
          end
          if (nxt_done) begin
            dout_q    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_ack   <= raw_q ? '0 : ack_in;
            rsp_rdata <= rd_ok ? dat_in[DATA_BITS-1:0] : '0;
            rsp_perr  <= rd_ok ? ^dat_in : 1'b0;
          end
        end
      end
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign swclk    = sclk_q;
  assign swdio_o  = dout_q;
  assign swdio_oe = oe_q;

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int DIV_W     = 8,
  parameter int TURN_BITS = 1,
  parameter int RAW_W     = $clog2(swd_host_pkg::DATA_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             req_valid,
  input  logic             req_raw,
  input  logic             req_ap,
  input  logic             req_rd,
  input  logic [1:0]       req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [RAW_W-1:0] req_raw_cnt,
  output logic             busy,
  output logic             rsp_valid,
  output logic [2:0]       rsp_ack,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_perr,
  output logic             swclk,
  output logic             swdio_o,
  output logic             swdio_oe,
  input  logic             swdio_i
);

  import swd_host_pkg::*;

  logic                 tick, cap_clr, smp_ack, smp_dat;
  logic [ACK_BITS-1:0]  ack_w;
  logic [DATA_BITS:0]   dat_w;

  swd_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .en   (busy),
    .div  (clk_div),
    .tick (tick)
  );

  swd_rx_capture #(.ACK_W(ACK_BITS), .DAT_W(DATA_BITS + 1)) cap_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (cap_clr),
    .smp_ack (smp_ack),
    .smp_dat (smp_dat),
    .din     (swdio_i),
    .ack_q   (ack_w),
    .dat_q   (dat_w)
  );

  swd_frame_seq #(.TURN_BITS(TURN_BITS), .RAW_W(RAW_W)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .req_valid   (req_valid),
    .req_raw     (req_raw),
    .req_ap      (req_ap),
    .req_rd      (req_rd),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_raw_cnt (req_raw_cnt),
    .ack_in      (ack_w),
    .dat_in      (dat_w),
    .busy        (busy),
    .cap_clr     (cap_clr),
    .smp_ack     (smp_ack),
    .smp_dat     (smp_dat),
    .swclk       (swclk),
    .swdio_o     (swdio_o),
    .swdio_oe    (swdio_oe),
    .rsp_valid   (rsp_valid),
    .rsp_ack     (rsp_ack),
    .rsp_rdata   (rsp_rdata),
    .rsp_perr    (rsp_perr)
  );

endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       req_valid,
  input logic       rsp_valid,
  input logic [2:0] rsp_ack,
  input logic       rsp_perr,
  input logic       swclk,
  input logic       swdio_o,
  input logic       swdio_oe
);

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!swclk && swdio_oe && !swdio_o));

  // R2
  drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (swclk && $past(swclk)) |-> ($stable(swdio_o) && $stable(swdio_oe)));

  // R2
  clk_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(swclk) |-> busy);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R6
  perr_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_perr) |-> (rsp_ack == 3'b001));

endmodule

bind swd_host_engine swd_host_engine_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_ack   (rsp_ack),
  .rsp_perr  (rsp_perr),
  .swclk     (swclk),
  .swdio_o   (swdio_o),
  .swdio_oe  (swdio_oe)
);

// File: tb/swd_host_engine_tb_top.sv
`timescale 1ns/1ps
module swd_host_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  clk_div = 8'd1;
  logic        req_valid = 1'b0, req_raw = 1'b0, req_ap = 1'b0, req_rd = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic [4:0]  req_raw_cnt = 5'd0;
  logic        busy, rsp_valid, rsp_perr, swclk, swdio_o, swdio_oe, swdio_i;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  swd_host_engine dut_i (
    .clk(clk), .rst(rst), .clk_div(clk_div), .req_valid(req_valid), .req_raw(req_raw),
    .req_ap(req_ap), .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_raw_cnt(req_raw_cnt), .busy(busy), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .swclk(swclk), .swdio_o(swdio_o),
    .swdio_oe(swdio_oe), .swdio_i(swdio_i)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // target model and wire recorder, indexed by rising-edge number
  logic        swclk_d;
  logic [6:0]  edge_idx;
  logic [63:0] host_bits, oe_bits, tgt_vec;

  assign swdio_i = tgt_vec[edge_idx[5:0]];

  always @(posedge clk) begin
    if (rst) begin
      swclk_d  <= 1'b0;
      edge_idx <= '0;
    end else begin
      swclk_d <= swclk;
      if (req_valid && !busy) begin
        edge_idx <= '0;
      end else if (swclk && !swclk_d) begin
        host_bits[edge_idx[5:0]] <= swdio_o;
        oe_bits[edge_idx[5:0]]   <= swdio_oe;
        edge_idx <= edge_idx + 1'b1;
      end
    end
  end

  // half-period length monitor
  logic tmg_clr = 1'b0;
  int hi_run = 0, lo_run = 0, hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0;

  always @(negedge clk) begin
    if (tmg_clr) begin
      hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
    end
    if (swclk) begin
      hi_run++;
      if (lo_run > 0) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
      end
      lo_run = 0;
    end else begin
      if (hi_run > 0) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
      end
      hi_run = 0;
      if (busy) lo_run++;
      else lo_run = 0;
    end
  end

  // scoreboard
  typedef struct {
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        perr;
    int          nbits;
    logic [63:0] hv;
    logic [63:0] hm;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   rsp_seen = 0;
  int   issued = 0;

  always @(negedge clk) begin : monitor
    exp_t e;
    logic [63:0] nm;
    if (!rst && rsp_valid) begin
      rsp_seen++;
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10", "response with nothing expected", 64'(rsp_ack), 64'd0);
      end else begin
        e  = sb_q.pop_front();
        nm = (e.nbits >= 64) ? '1 : ((64'd1 << e.nbits) - 64'd1);
        chk(rsp_ack == e.ack, e.tag, "ack", 64'(rsp_ack), 64'(e.ack));
        chk(rsp_rdata == e.rdata, e.tag, "rdata", 64'(rsp_rdata), 64'(e.rdata));
        chk(rsp_perr == e.perr, e.tag, "perr", 64'(rsp_perr), 64'(e.perr));
        chk(edge_idx == 7'(e.nbits), e.tag, "wire bit count", 64'(edge_idx), 64'(e.nbits));
        chk((host_bits & e.hm) == (e.hv & e.hm), e.tag, "driven bits",
            host_bits & e.hm, e.hv & e.hm);
        chk((oe_bits & nm) == e.hm, e.tag, "output enable pattern", oe_bits & nm, e.hm);
      end
    end
  end

  // build expectation and target response from the requirements
  task automatic prep(input bit raw, input bit ap, input bit rd, input logic [1:0] a,
                      input logic [31:0] wd, input logic [4:0] rc, input logic [2:0] tack,
                      input logic [31:0] trd, input bit bad_par, input string tag);
    exp_t e;
    logic [63:0] t;
    logic [7:0]  h;
    t = '0;
    e.hv = '0; e.hm = '0; e.ack = 3'd0; e.rdata = 32'd0; e.perr = 1'b0; e.tag = tag;
    if (raw) begin
      e.nbits = int'(rc) + 1;
      e.hv[31:0] = wd;
      e.hm = (64'd1 << e.nbits) - 64'd1;
    end else begin
      h = {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
      e.hv[7:0] = h;
      e.hm[7:0] = 8'hFF;
      t[11:9] = tack;
      e.ack = tack;
      if (tack != 3'b001) begin
        e.nbits = 13;
      end else if (rd) begin
        e.nbits = 46;
        t[43:12] = trd;
        t[44] = ^trd ^ bad_par;
        e.rdata = trd;
        e.perr = bad_par;
      end else begin
        e.nbits = 46;
        e.hv[44:13] = wd;
        e.hv[45] = ^wd;
        e.hm[45:13] = '1;
      end
    end
    tgt_vec = t;
    sb_q.push_back(e);
    issued++;
  endtask

  task automatic drive(input bit raw, input bit ap, input bit rd, input logic [1:0] a,
                       input logic [31:0] wd, input logic [4:0] rc);
    req_raw = raw; req_ap = ap; req_rd = rd; req_addr = a; req_wdata = wd; req_raw_cnt = rc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (rsp_seen != issued || busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input bit raw, input bit ap, input bit rd, input logic [1:0] a,
                     input logic [31:0] wd, input logic [4:0] rc, input logic [2:0] tack,
                     input logic [31:0] trd, input bit bad_par, input string tag);
    prep(raw, ap, rd, a, wd, rc, tack, trd, bad_par, tag);
    @(negedge clk);
    drive(raw, ap, rd, a, wd, rc);
    wait_done();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    tgt_vec = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !swclk && swdio_oe && !swdio_o && !rsp_valid, "R1", "idle after reset",
        {60'd0, busy, swclk, swdio_oe, swdio_o}, 64'h2);

    // R3 R5 OK write to debug port
    run(0, 0, 0, 2'b01, 32'hA5A5_1234, 5'd0, 3'b001, 32'd0, 0, "R5");
    // R1 idle line between transactions
    chk(!busy && !swclk && swdio_oe && !swdio_o, "R1", "idle between",
        {60'd0, busy, swclk, swdio_oe, swdio_o}, 64'h2);
    // R3 R4 R6 OK read from access port
    run(0, 1, 1, 2'b11, 32'hDEAD_BEEF, 5'd0, 3'b001, 32'hDEAD_BEEF, 0, "R6");
    run(0, 1, 1, 2'b10, 32'd0, 5'd0, 3'b001, 32'h0000_0001, 0, "R4");
    // R6 parity error
    run(0, 0, 1, 2'b00, 32'd0, 5'd0, 3'b001, 32'h1357_9BDF, 1, "R6");
    // R7 non-OK acknowledges
    run(0, 1, 1, 2'b01, 32'd0, 5'd0, 3'b010, 32'hFFFF_FFFF, 0, "R7");
    run(0, 0, 0, 2'b10, 32'h0F0F_0F0F, 5'd0, 3'b100, 32'd0, 0, "R7");
    // R8 raw bursts: full 32 ones, then an 8-bit pattern
    run(1, 0, 0, 2'b00, 32'hFFFF_FFFF, 5'd31, 3'b000, 32'd0, 0, "R8");
    run(1, 0, 0, 2'b00, 32'hFFFF_FF9E, 5'd7, 3'b000, 32'd0, 0, "R8");
    run(1, 0, 0, 2'b00, 32'h0000_0001, 5'd0, 3'b000, 32'd0, 0, "R8");

    // R2 half periods with a slower divider
    clk_div = 8'd3;
    tmg_clr = 1'b1;
    @(negedge clk);
    tmg_clr = 1'b0;
    run(0, 1, 0, 2'b00, 32'h8000_0001, 5'd0, 3'b001, 32'd0, 0, "R2");
    chk(hi_min == 4 && hi_max == 4, "R2", "high phase length",
        64'(hi_min * 1000 + hi_max), 64'(4004));
    chk(lo_min == 4 && lo_max == 4, "R2", "low phase length",
        64'(lo_min * 1000 + lo_max), 64'(4004));
    clk_div = 8'd1;

    // R10 request strobe during a read is ignored
    prep(0, 1, 1, 2'b01, 32'd0, 5'd0, 3'b001, 32'h2468_ACE0, 0, "R10");
    @(negedge clk);
    drive(0, 1, 1, 2'b01, 32'd0, 5'd0);
    repeat (60) @(negedge clk);
    drive(1, 0, 0, 2'b00, 32'hFFFF_FFFF, 5'd31);
    wait_done();
    repeat (20) @(negedge clk);
    chk(!busy && !swclk && rsp_seen == issued, "R10", "no activity after dropped strobe",
        64'(rsp_seen), 64'(issued));

    // R9 completion and next acceptance in the same cycle
    prep(0, 0, 0, 2'b11, 32'hCAFE_F00D, 5'd0, 3'b001, 32'd0, 0, "R9");
    @(negedge clk);
    drive(0, 0, 0, 2'b11, 32'hCAFE_F00D, 5'd0);
    prep(0, 1, 1, 2'b00, 32'd0, 5'd0, 3'b001, 32'h55AA_33CC, 0, "R9");
    req_raw = 0; req_ap = 1; req_rd = 1; req_addr = 2'b00; req_wdata = 32'd0;
    req_valid = 1'b1;
    while (!rsp_valid) @(negedge clk);
    chk(!busy, "R9", "busy low with response", 64'(busy), 64'd0);
    @(negedge clk);
    chk(busy && !rsp_valid, "R9", "next request taken at once",
        {62'd0, busy, rsp_valid}, 64'h2);
    req_valid = 1'b0;
    wait_done();
    chk(sb_q.size() == 0, "R9", "all responses seen", 64'(sb_q.size()), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule